// File: doc/BRIEF.md
# Falling-Edge Event Counter with Atomic Read-and-Clear

This block counts falling transitions on an external line that is not related to the system clock. The line first passes through a chain of synchronizer flops. A high-to-low change is then detected in the system clock domain. While the count enable is high, each detected change adds one to a counter that is 32 bits wide by default and wraps at the top.

A consumer asks for the count with one of two one-cycle strobes. The plain read strobe returns the count and leaves it as it is. The read-and-clear strobe returns the count as it stood just before the clear, and it zeroes the counter in the same cycle. If an edge is detected in that same cycle, the counter restarts at one, so no event is lost. The returned word appears one cycle after the strobe, together with a one-cycle valid flag.

The system clock must run fast enough to sample every high and low phase of the input at least once. For phases of 125 ns, that means a clock period below 125 ns.

Top module: `fall_edge_counter`

## Requirements
- R1: After reset, rd_valid is 0, rd_data is 0 and the count is 0. A read straight after reset returns 0.
- R2: Each high-to-low transition of pin_async while cnt_en is 1 adds exactly one to the count. Low-to-high transitions add nothing.
- R3: Let k be the first clock edge that samples pin_async low after it was high. A read sampled at edge k+2 does not yet include that edge. A read sampled at edge k+3 or later includes it.
- R4: A strobe on rd_req or rd_clr_req sampled at a clock edge sets rd_valid to 1 for exactly the following cycle. With no strobe, rd_valid is 0 in the following cycle. A plain read leaves the count unchanged.
- R5: The rd_data that accompanies rd_valid equals the count held in the cycle of the strobe, before any clear or increment from that cycle.
- R6: A rd_clr_req zeroes the count. If an edge is detected in the cycle of the clear while cnt_en is 1, the count becomes 1 instead.
- R7: While cnt_en is 0, the count holds its value and ignores edges on pin_async. A rd_clr_req still zeroes it.
- R8: The count wraps from all ones (0xFFFFFFFF at the default width of 32 bits) to zero, with no saturation.
- R9: When rd_req and rd_clr_req are both 1 in the same cycle, the block acts as a read-and-clear.
- R10: High and low phases of pin_async as short as one clock period are each seen, and every such fall is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable; edges are ignored while low |
| pin_async | input | 1 | External event line, asynchronous to clk |
| rd_req | input | 1 | One-cycle strobe: read the count |
| rd_clr_req | input | 1 | One-cycle strobe: read the count, then clear it |
| rd_valid | output | 1 | High for one cycle when rd_data carries a result |
| rd_data | output | CNT_W | Count captured at the strobe |

## Verification
A change on pin_async first sampled at edge k reaches the counter at edge k+2, so a read strobe sampled at edge k+3 or later returns it. The result of a strobe sampled at edge e is on rd_data and rd_valid right after edge e, and the bench samples it at the next falling clock edge. Random bursts are checked only after the line has been idle high for four cycles, so every edge has landed before the read. Directed cases place the strobe at edge k+2 and k+3 to pin down both the latency boundary and the kept edge in the clearing cycle. A second instance, 4 bits wide, gets the same stimulus so that wrap-around is exercised in a short run.

// File: rtl/fec_pkg.sv
// Package: shared types for the falling-edge event counter.
// Assumes: none; it holds types and a pure decode function only.
package fec_pkg;

    // What the counter is asked to do in a given cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_CLEAR = 2'd2
    } fec_op_e;

    // Map the two request strobes to one operation; the clear wins (R9).
    function automatic fec_op_e fec_decode(input logic rd, input logic clr);
        fec_op_e op;
        if (clr)
            op = OP_CLEAR;
        else if (rd)
            op = OP_READ;
        else
            op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/fec_sync.sv
// Module: fec_sync
// Chain of STAGES flops that brings an asynchronous line into the clk domain.
// Assumes: STAGES >= 2. Flops reset to 0, so a high line after reset gives a
// rising change only and never a false fall.
module fec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage: sample the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: pass the value one flop further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/fec_fall_detect.sv
// Module: fec_fall_detect
// Raises fall for one cycle when the synchronized line goes from 1 to 0.
// Assumes: sig_sync is already in the clk domain.
module fec_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_sync,
    output logic fall
);

    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_sync;
    end

    assign fall = prev_q & ~sig_sync;

endmodule

// File: rtl/fec_accum.sv
// Module: fec_accum
// Holds the event count. It adds one per enabled fall and clears on
// OP_CLEAR. A fall in the clearing cycle is kept, so the count becomes 1.
// Assumes: op comes from fec_decode; the count wraps modulo 2**CNT_W.
module fec_accum
    import fec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fall,
    input  fec_op_e          op,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic bump;
    assign bump = en & fall;

    // Update the count: a clear has priority, and a same-cycle edge is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (op == OP_CLEAR)
            cnt_q <= bump ? ONE : '0;
        else if (bump)
            cnt_q <= cnt_q + ONE;
    end

endmodule

// File: rtl/fec_readout.sv
// Module: fec_readout
// Captures the count that stands in the cycle of a read or clear request,
// and flags it with a one-cycle valid.
// Assumes: cnt is the register output, so the captured value is pre-update.
module fec_readout
    import fec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fec_op_e          op,
    input  logic [CNT_W-1:0] cnt,
    output logic             vld,
    output logic [CNT_W-1:0] data
);

    // Raise the result flag in the cycle after any request.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= (op != OP_IDLE);
    end

    // Latch the count when a request is seen; otherwise hold the last result.
    always_ff @(posedge clk) begin
        if (!rst_n)             data <= '0;
        else if (op != OP_IDLE) data <= cnt;
    end

endmodule

// File: rtl/fall_edge_counter.sv
// Module: fall_edge_counter (top)
// Counts falling edges of an asynchronous line, with plain read and atomic
// read-and-clear. Path: synchronizer -> fall detector -> accumulator ->
// readout register.
// Assumes: clk samples every high and low phase of pin_async at least once;
// the strobes are synchronous to clk.
module fall_edge_counter
    import fec_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             pin_async,
    input  logic             rd_req,
    input  logic             rd_clr_req,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data
);

    logic             pin_sync;
    logic             fall_pulse;
    fec_op_e          op;
    logic [CNT_W-1:0] cnt_q;

    assign op = fec_decode(rd_req, rd_clr_req);

    fec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (pin_sync)
    );

    fec_fall_detect u_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_sync (pin_sync),
        .fall     (fall_pulse)
    );

    fec_accum #(.CNT_W(CNT_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .fall  (fall_pulse),
        .op    (op),
        .cnt_q (cnt_q)
    );

    fec_readout #(.CNT_W(CNT_W)) u_readout (
        .clk  (clk),
        .rst_n(rst_n),
        .op   (op),
        .cnt  (cnt_q),
        .vld  (rd_valid),
        .data (rd_data)
    );

endmodule

// File: rtl/fec_checker.sv
// Module: fec_checker
// Temporal checks on the counter's strobes, results and count register.
// It is bound into fall_edge_counter and watches the internal count.
// Assumes: synchronous active-low reset; the bench holds inputs at 0 in reset.
module fec_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             rd_req,
    input logic             rd_clr_req,
    input logic             rd_valid,
    input logic [CNT_W-1:0] rd_data,
    input logic [CNT_W-1:0] count
);

    AST_RD_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || rd_clr_req) |=> rd_valid); // R4
    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req || rd_clr_req) |=> !rd_valid); // R4
    AST_RD_PRE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || rd_clr_req) |=> (rd_data == $past(count))); // R5
    AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_req |=> (count <= CNT_W'(1))); // R6
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !rd_clr_req) |=> (count == $past(count))); // R7
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_req |=> ((count == $past(count)) ||
                         (count == CNT_W'($past(count) + CNT_W'(1))))); // R8

endmodule

bind fall_edge_counter fec_checker #(.CNT_W(CNT_W)) u_fec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .rd_req     (rd_req),
    .rd_clr_req (rd_clr_req),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .count      (cnt_q)
);

// File: tb/fall_edge_counter_bench.sv
// Bench: drives a 32-bit and a 4-bit counter with the same stimulus and
// checks both against a count kept in the bench. Inputs change on falling
// clock edges, and results are sampled on falling clock edges.
module fall_edge_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        pin_async = 1'b1;
    logic        rd_req = 1'b0;
    logic        rd_clr_req = 1'b0;
    logic        vld_a, vld_b;
    logic [31:0] data_a;
    logic [3:0]  data_b;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] exp_cnt = 0;

    always #10 clk = ~clk;

    fall_edge_counter u_fall_edge_counter (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pin_async(pin_async),
        .rd_req(rd_req), .rd_clr_req(rd_clr_req), .rd_valid(vld_a), .rd_data(data_a)
    );

    fall_edge_counter #(.CNT_W(4)) u_fall_edge_counter_w4 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pin_async(pin_async),
        .rd_req(rd_req), .rd_clr_req(rd_clr_req), .rd_valid(vld_b), .rd_data(data_b)
    );

    function automatic logic [3:0] narrow(input logic [31:0] v);
        return v[3:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling clock edge.
    task automatic pulse(input int lo, input int hi);
        pin_async = 1'b0;
        repeat (lo) @(negedge clk);
        pin_async = 1'b1;
        repeat (hi) @(negedge clk);
        if (cnt_en) exp_cnt = exp_cnt + 1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Issue a strobe; check valid, data and the valid drop one cycle later.
    task automatic request(input bit rd, input bit clr, input string req);
        rd_req = rd;
        rd_clr_req = clr;
        @(negedge clk);
        rd_req = 1'b0;
        rd_clr_req = 1'b0;
        chk({req, " valid"}, {31'd0, vld_a}, 32'd1);
        chk({req, " data"}, data_a, exp_cnt);
        chk({req, " R8 data_w4"}, {28'd0, data_b}, {28'd0, narrow(exp_cnt)});
        if (clr) exp_cnt = 0;
        @(negedge clk);
        chk("R4 valid drops", {31'd0, vld_a}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_valid in reset", {31'd0, vld_a}, 32'd0);
        chk("R1 rd_data in reset", data_a, 32'd0);
        rst_n = 1'b1;
        settle();
        request(1'b1, 1'b0, "R1 read after reset");

        // R2: one count per fall, rises add nothing
        cnt_en = 1'b1;
        pulse(3, 3); pulse(2, 5); pulse(4, 2);
        settle();
        request(1'b1, 1'b0, "R2 three falls");
        request(1'b1, 1'b0, "R4 plain read keeps count");

        // R3: latency boundary; pin low is first sampled at edge k
        pin_async = 1'b0;                 // sampled at edge k
        @(negedge clk);                   // after k
        @(negedge clk); rd_req = 1'b1;    // strobe sampled at k+2
        @(negedge clk);                   // strobe held for k+3
        chk("R3 read at k+2 excludes edge", data_a, exp_cnt);
        @(negedge clk); rd_req = 1'b0;
        exp_cnt = exp_cnt + 1;
        chk("R3 read at k+3 includes edge", data_a, exp_cnt);
        pin_async = 1'b1;
        settle();

        // R6: clear in the same cycle as a detected edge keeps the edge
        pin_async = 1'b0;
        @(negedge clk);
        @(negedge clk); rd_clr_req = 1'b1;  // sampled at k+2, with the fall
        @(negedge clk); rd_clr_req = 1'b0;
        chk("R6 pre-clear value", data_a, exp_cnt);
        exp_cnt = 1;
        pin_async = 1'b1;
        settle();
        request(1'b1, 1'b0, "R6 edge kept after clear");

        // R10: one-cycle phases
        pulse(1, 1); pulse(1, 1); pulse(1, 1);
        settle();
        request(1'b1, 1'b0, "R10 single-cycle phases");

        // R7: disabled holds and ignores, clear still works
        cnt_en = 1'b0;
        pulse(2, 2); pulse(3, 3);
        settle();
        request(1'b1, 1'b0, "R7 edges ignored when off");
        request(1'b0, 1'b1, "R7 clear when off");
        request(1'b1, 1'b0, "R7 zero after clear");

        // R8: 4-bit instance wraps after 16 falls
        cnt_en = 1'b1;
        for (int i = 0; i < 17; i++) pulse(1, 2);
        settle();
        request(1'b1, 1'b0, "R8 wrap");

        // R9: both strobes act as read-and-clear
        request(1'b1, 1'b1, "R9 both strobes");
        request(1'b1, 1'b0, "R9 zero after both");

        // Random mix
        for (int it = 0; it < 80; it++) begin
            int nf, act;
            if (($urandom % 4) == 0) cnt_en = ~cnt_en;
            nf = $urandom_range(0, 6);
            for (int p = 0; p < nf; p++)
                pulse($urandom_range(1, 6), $urandom_range(1, 6));
            settle();
            act = $urandom % 4;
            if (act < 2)       request(1'b1, 1'b0, "R2 random read");
            else if (act == 2) request(1'b0, 1'b1, "R5 random clear");
            else               request(1'b1, 1'b1, "R9 random both");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule